// File: doc/BRIEF.md
# I2S Master Receiver with Sample Packing

This block is the receiving end of an I2S link on which the chip is the clock master. While its enable input is high it produces the bit clock and the word-select line, samples the serial data line, and rebuilds one 32-bit slot per channel. A packing stage turns the slots it keeps into 32-bit words: two 16-bit samples per word, one 16-bit sample per word, or one 24-bit sample per word with its lowest byte zero. A channel selector keeps both channels, the right only or the left only.

Words go into an internal receive FIFO that a downstream mover drains through a simple read strobe. A word counter raises a one-cycle trigger after a programmable number of 4-byte words have been accepted, so that a DMA engine can be told a block is ready. If a word arrives while the FIFO is full, the word is dropped and a sticky overflow flag is set.

Top module: `i2s_master_rx`

## Requirements
- R1: While enabled, the bit clock has a period of 2*HALF_DIV system cycles. Word-select is low (left) for 32 bit-clock periods and high (right) for the next 32, and changes only in the cycle after a falling bit-clock edge.
- R2: While disabled, the bit clock and word-select are held low and no new word is produced.
- R3: Data is sampled on rising bit-clock edges, MSB first, starting one bit period after word-select changes. Each slot is 32 bits. The first slot after enable is the left slot.
- R4: Packing mode 0 puts two consecutive kept samples, each the upper 16 bits of its slot, in one word. The earlier sample goes in bits [31:16].
- R5: Packing mode 1 writes one word per kept sample, with the slot's upper 16 bits in [31:16] and zero in [15:0]. With channel mode 0, the half modes (1 and 3) keep only the left slot.
- R6: Packing modes 2 and 3 write one word per kept sample, with the slot's upper 24 bits in [31:8] and zero in [7:0].
- R7: Packing modes 4 to 7 and channel mode 3 produce no words.
- R8: Channel mode 0 keeps both slots, mode 1 only the right slot (word-select high), and mode 2 only the left slot.
- R9: After eof_thresh words have been accepted since enable, eof_pulse is high for exactly one cycle and the count restarts. A threshold of 0 never pulses.
- R10: A word that arrives while the FIFO is full is dropped, the words already stored are kept, and overflow rises and stays high until reset.
- R11: A read request while the FIFO is not empty returns the oldest word on rd_data, with rd_valid high, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Run the receiver and its clocks |
| pack_mode | input | 3 | Word packing format (0..3 valid) |
| chan_mode | input | 2 | Channel keep selection (0..2 valid) |
| eof_thresh | input | THR_W | Words per trigger, 0 disables |
| sd_in | input | 1 | Serial data from the transmitter |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, high for the right slot |
| rd_req | input | 1 | Read strobe for the FIFO |
| rd_data | output | 32 | Word read from the FIFO |
| rd_valid | output | 1 | rd_data holds a newly read word |
| fifo_empty | output | 1 | FIFO holds no word |
| eof_pulse | output | 1 | Word-count trigger |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench builds the block with HALF_DIV=2, so a frame is 256 system cycles and many frames fit in a short run in every packing and channel combination. It uses DEPTH=4, so that withholding reads for four frames overfills the FIFO, which shows the dropped words, the sticky flag and the intact stored words. Thresholds of 0, 1 and 2 reach the disabled, every-word and multi-word trigger cases.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int SLOT_W = 32;

  typedef enum logic [1:0] {
    CH_BOTH  = 2'd0,
    CH_RIGHT = 2'd1,
    CH_LEFT  = 2'd2,
    CH_NONE  = 2'd3
  } chan_sel_e;

  localparam logic [2:0] PK_16_PAIR = 3'd0;
  localparam logic [2:0] PK_16_ONE  = 3'd1;
  localparam logic [2:0] PK_24_FULL = 3'd2;
  localparam logic [2:0] PK_24_HALF = 3'd3;
endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          bclk_q;
  logic          tick;

  assign tick   = en && (cnt == CW'(HALF_DIV - 1));
  assign rise_o = tick && !bclk_q;
  assign fall_o = tick && bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bclk_q); // R2
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rise,
  input  logic              fall,
  input  logic              sd,
  output logic              ws_o,
  output logic              smp_vld,
  output logic [SLOT_W-1:0] smp_data,
  output logic              smp_right
);
  localparam int SW = $clog2(SLOT_W);

  logic [SW:0]       bitcnt;
  logic [SLOT_W-1:0] shreg;
  logic [SLOT_W-1:0] shnext;
  logic              primed;

  assign shnext = {shreg[SLOT_W-2:0], sd};
  assign ws_o   = bitcnt[SW];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bitcnt    <= '0;
      shreg     <= '0;
      primed    <= 1'b0;
      smp_vld   <= 1'b0;
      smp_data  <= '0;
      smp_right <= 1'b0;
    end else begin
      smp_vld <= 1'b0;
      if (fall) bitcnt <= bitcnt + 1'b1;
      if (rise) begin
        shreg  <= shnext;
        primed <= 1'b1;
        if (primed && bitcnt[SW-1:0] == '0) begin
          smp_vld   <= 1'b1;
          smp_data  <= shnext;
          smp_right <= ~bitcnt[SW];
        end
      end
    end
  end

  AST_WS_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (ws_o != $past(ws_o))) |-> $past(fall)); // R1
endmodule

// File: rtl/i2s_rx_packer.sv
module i2s_rx_packer
  import i2s_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        pack_mode,
  input  logic [1:0]        chan_mode,
  input  logic              smp_vld,
  input  logic [SLOT_W-1:0] smp_data,
  input  logic              smp_right,
  output logic              wr_vld,
  output logic [31:0]       wr_data
);
  logic        half_mode;
  logic        keep;
  logic        pend;
  logic [15:0] hold;

  assign half_mode = (pack_mode == PK_16_ONE) || (pack_mode == PK_24_HALF);

  always_comb begin
    unique case (chan_sel_e'(chan_mode))
      CH_BOTH:  keep = half_mode ? !smp_right : 1'b1;
      CH_RIGHT: keep = smp_right;
      CH_LEFT:  keep = !smp_right;
      default:  keep = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wr_vld  <= 1'b0;
      wr_data <= '0;
      pend    <= 1'b0;
      hold    <= '0;
    end else begin
      wr_vld <= 1'b0;
      if (smp_vld && keep) begin
        case (pack_mode)
          PK_16_PAIR: begin
            if (pend) begin
              wr_vld  <= 1'b1;
              wr_data <= {hold, smp_data[SLOT_W-1 -: 16]};
              pend    <= 1'b0;
            end else begin
              hold <= smp_data[SLOT_W-1 -: 16];
              pend <= 1'b1;
            end
          end
          PK_16_ONE: begin
            wr_vld  <= 1'b1;
            wr_data <= {smp_data[SLOT_W-1 -: 16], 16'h0000};
          end
          PK_24_FULL, PK_24_HALF: begin
            wr_vld  <= 1'b1;
            wr_data <= {smp_data[SLOT_W-1 -: 24], 8'h00};
          end
          default: ;
        endcase
      end
    end
  end

  AST_NO_INVALID_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> ($past(pack_mode) <= 3'd3 && $past(chan_mode) != 2'd3)); // R7
  AST_LOW_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && $past(pack_mode[1])) |-> (wr_data[7:0] == 8'h00)); // R6
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr;
  logic [AW:0]  rptr;
  logic         do_wr;
  logic         do_rd;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= do_rd;
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) <= (AW+1)'(DEPTH)); // R10
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty) |=> rvalid); // R11
endmodule

// File: rtl/i2s_master_rx.sv
module i2s_master_rx
  import i2s_rx_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int DEPTH    = 8,
  parameter int THR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic [2:0]       pack_mode,
  input  logic [1:0]       chan_mode,
  input  logic [THR_W-1:0] eof_thresh,
  input  logic             sd_in,
  output logic             bclk_o,
  output logic             ws_o,
  input  logic             rd_req,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             fifo_empty,
  output logic             eof_pulse,
  output logic             overflow
);
  logic              rise, fall;
  logic              smp_vld, smp_right;
  logic [SLOT_W-1:0] smp_data;
  logic              wr_vld;
  logic [31:0]       wr_data;
  logic              full;
  logic              en_d;
  logic [THR_W-1:0]  wcnt;

  i2s_rx_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .en(rx_en),
    .bclk_o(bclk_o), .rise_o(rise), .fall_o(fall)
  );

  i2s_rx_deser u_deser (
    .clk(clk), .rst(rst), .en(rx_en), .rise(rise), .fall(fall), .sd(sd_in),
    .ws_o(ws_o), .smp_vld(smp_vld), .smp_data(smp_data), .smp_right(smp_right)
  );

  i2s_rx_packer u_pack (
    .clk(clk), .rst(rst), .en(rx_en), .pack_mode(pack_mode), .chan_mode(chan_mode),
    .smp_vld(smp_vld), .smp_data(smp_data), .smp_right(smp_right),
    .wr_vld(wr_vld), .wr_data(wr_data)
  );

  i2s_rx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_vld), .wdata(wr_data), .full(full),
    .pop(rd_req), .rdata(rd_data), .rvalid(rd_valid), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d      <= 1'b0;
      wcnt      <= '0;
      eof_pulse <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      en_d      <= rx_en;
      eof_pulse <= 1'b0;
      if (rx_en && !en_d) begin
        wcnt <= '0;
      end else if (wr_vld) begin
        if (full) begin
          overflow <= 1'b1;
        end else if (eof_thresh != '0) begin
          if (wcnt == eof_thresh - 1'b1) begin
            eof_pulse <= 1'b1;
            wcnt      <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      end
    end
  end

  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |=> !eof_pulse); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow); // R10
  AST_NO_EOF_ZERO_THR: assert property (@(posedge clk) disable iff (rst)
    ($past(eof_thresh) == '0) |-> !eof_pulse); // R9
endmodule

// File: tb/i2s_master_rx_bench.sv
`timescale 1ns/1ps
module i2s_master_rx_bench;
  localparam int HALF_DIV = 2;
  localparam int DEPTH    = 4;
  localparam int THR_W    = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             rx_en = 1'b0;
  logic [2:0]       pack_mode = '0;
  logic [1:0]       chan_mode = '0;
  logic [THR_W-1:0] eof_thresh = '0;
  logic             sd_in = 1'b0;
  logic             rd_req = 1'b0;
  logic             bclk_o, ws_o, rd_valid, fifo_empty, eof_pulse, overflow;
  logic [31:0]      rd_data;

  i2s_master_rx #(.HALF_DIV(HALF_DIV), .DEPTH(DEPTH), .THR_W(THR_W)) u_i2s_master_rx (
    .clk(clk), .rst(rst), .rx_en(rx_en), .pack_mode(pack_mode), .chan_mode(chan_mode),
    .eof_thresh(eof_thresh), .sd_in(sd_in), .bclk_o(bclk_o), .ws_o(ws_o),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .fifo_empty(fifo_empty),
    .eof_pulse(eof_pulse), .overflow(overflow)
  );

  int total = 0, bad = 0;
  int cyc = 0, nfall = 0, last_rise = -1;
  bit en_seen = 0, checking = 0, reading = 0, pend = 0;
  int mpack = 0, mchan = 0, mthr = 0, mcnt = 0, eof_exp = 0, eof_got = 0;
  logic [15:0] hold;
  logic [31:0] q[$];
  string tag = "R3";

  function automatic logic [31:0] slot_val(int s);
    return 32'(s) * 32'h9E3779B1 + 32'h0F1E2D3C;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_push(logic [31:0] w);
    if (!reading && q.size() >= DEPTH) return;
    q.push_back(w);
    if (mthr != 0) begin
      mcnt++;
      if (mcnt == mthr) begin
        eof_exp++;
        mcnt = 0;
      end
    end
  endtask

  task automatic model_emit(int s);
    logic [31:0] v;
    bit right, half, keep;
    v = slot_val(s);
    right = (s % 2) == 1;
    half = (mpack == 1) || (mpack == 3);
    case (mchan)
      0: keep = half ? !right : 1'b1;
      1: keep = right;
      2: keep = !right;
      default: keep = 1'b0;
    endcase
    if (!keep) return;
    case (mpack)
      0: if (pend) begin model_push({hold, v[31:16]}); pend = 0; end
         else begin hold = v[31:16]; pend = 1; end
      1: model_push({v[31:16], 16'h0000});
      2, 3: model_push({v[31:8], 8'h00});
      default: ;
    endcase
  endtask

  // transmitter side: new bit after every falling bit-clock edge (R3)
  always @(negedge bclk_o) begin
    if (rx_en) begin
      logic [31:0] v;
      int k;
      nfall++;
      k = nfall - 1;
      v = slot_val(k / 32);
      sd_in = v[31 - (k % 32)];
    end
  end

  always @(posedge bclk_o) begin
    if (rx_en) begin
      if (last_rise >= 0)
        check(cyc - last_rise == 2 * HALF_DIV, "R1", "bit clock period",
              32'(cyc - last_rise), 32'(2 * HALF_DIV));
      last_rise = cyc;
      if (nfall > 0 && nfall % 32 == 0) model_emit(nfall / 32 - 1);
    end
  end

  always @(posedge clk) en_seen <= rx_en;

  // per-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (checking) begin
      if (!en_seen)
        check(bclk_o == 1'b0 && ws_o == 1'b0, "R2", "idle clocks", {bclk_o, ws_o}, 0);
      else
        check(ws_o == ((nfall % 64) >= 32), "R1", "word select", ws_o, ((nfall % 64) >= 32));
      if (eof_pulse) eof_got++;
      if (rd_valid) begin
        if (q.size() == 0) check(0, "R11", "unexpected word", rd_data, 0);
        else begin
          logic [31:0] e;
          e = q.pop_front();
          check(rd_data == e, tag, "word value", rd_data, e);
        end
      end
    end
  end

  task automatic run(int pk, int ch, int thr, int frames, bit rd, string t);
    @(negedge clk);
    pack_mode = 3'(pk); chan_mode = 2'(ch); eof_thresh = THR_W'(thr);
    rd_req = rd; reading = rd; tag = t;
    mpack = pk; mchan = ch; mthr = thr; mcnt = 0; pend = 0;
    eof_exp = 0; eof_got = 0; nfall = 0; last_rise = -1; sd_in = 0;
    rx_en = 1;
    while (nfall < 64 * frames + 8) @(negedge clk);
    rx_en = 0;
    repeat (30) @(negedge clk);
    if (rd) check(q.size() == 0, t, "words not delivered", 32'(q.size()), 0);
    check(eof_got == eof_exp, "R9", "trigger count", 32'(eof_got), 32'(eof_exp));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(bclk_o == 0 && ws_o == 0, "R2", "reset clocks", {bclk_o, ws_o}, 0);
    check(fifo_empty == 1 && rd_valid == 0, "R11", "reset fifo", {fifo_empty, rd_valid}, 2);
    check(eof_pulse == 0 && overflow == 0, "R9", "reset flags", {eof_pulse, overflow}, 0);
    checking = 1;
    run(0, 0, 2, 3, 1, "R4");   // 16-bit pairs, both channels
    run(1, 0, 0, 3, 1, "R5");   // 16-bit single, dual -> left only; R9 threshold 0
    run(2, 1, 1, 3, 1, "R8");   // 24-bit, right only, trigger every word
    run(3, 2, 2, 3, 1, "R6");   // 24-bit half, left only
    run(0, 2, 1, 4, 1, "R4");   // pairs of left samples
    run(2, 0, 3, 3, 1, "R6");   // 24-bit both channels
    run(1, 1, 0, 2, 1, "R5");   // 16-bit single, right only
    run(5, 0, 1, 2, 1, "R7");   // invalid packing
    run(2, 3, 1, 2, 1, "R7");   // invalid channel mode
    check(overflow == 0, "R10", "no false overflow", overflow, 0);
    run(2, 0, 2, 4, 0, "R10");  // no reads: overfill
    check(overflow == 1, "R10", "overflow raised", overflow, 1);
    check(q.size() == DEPTH, "R10", "model fill", 32'(q.size()), 32'(DEPTH));
    @(negedge clk);
    rd_req = 1; reading = 1;
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R11", "stored words drained", 32'(q.size()), 0);
    check(overflow == 1, "R10", "overflow sticky", overflow, 1);
    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule